// File: doc/BRIEF.md
# Synchronized Multi-Converter Trigger Distributor

This block takes one trigger event and turns it into start commands for a group of two or three converter units. The parallel modes start every unit in the group on the same clock cycle. The delayed modes issue a staggered chain of starts, unit 1 first, with a programmable number of idle cycles between neighbours. The block also drives a run level for each unit. In the cyclic modes that level tells the unit to keep scanning until a stop request arrives. In the single-shot modes it stays low, and only the start pulses are issued.

The mode, group and delay inputs are plain levels, normally from configuration registers. The block samples the delay, the group and the cyclic flag when it accepts a trigger, and it uses those copies until that staggered chain is finished. While a chain is still being issued, the block ignores further triggers. Taking the enable low, or selecting a reserved mode code, returns the block to idle.

Top module: `sync_trig_ctrl`

## Requirements
- R1: After reset, all start pulses and all run levels are low.
- R2: Mode code 2 (mode bit 1 = parallel, bit 2 = 0) is single-shot parallel. A trigger sampled at a clock edge raises the start bit of every unit in the group in the cycle that follows, for exactly one cycle. The run levels stay low.
- R3: With the group select at 0, only units 1 and 2 take part (start/run bits 0 and 1). With it at 1, units 1 to 3 take part (bits 0 to 2). A bit outside the group never rises.
- R4: Mode code 0 is single-shot delayed. Start bit 0 pulses in the cycle after the trigger is sampled. Bit 1 then pulses, and bit 2 too when it is in the group, each one in turn.
- R5: In the delayed modes, consecutive start pulses are exactly D+1 cycles apart, where D is the 8-bit delay value. D = 0 gives back-to-back cycles and D = 255 gives 256 cycles.
- R6: The block captures the delay, the group select and the cyclic flag with the accepted trigger. Changing them while a chain is in progress does not alter that chain.
- R7: A trigger is ignored from the edge that accepts it up to and including the edge that issues the last start of its chain. A trigger sampled at any later edge is accepted.
- R8: Mode code 6 is cyclic parallel. The run levels of all group units rise together with their start pulses and stay high.
- R9: Mode code 4 is cyclic delayed. Each unit's run level rises in the same cycle as its own start pulse and stays high. A run level never rises without its start pulse.
- R10: A stop request sampled at an edge clears every run level and cancels any pending starts. A trigger sampled at the same edge is ignored, so no start follows it.
- R11: While the enable is low, no start pulse is issued and all run levels are cleared from the next cycle on.
- R12: The odd mode codes 1, 3, 5 and 7 (mode bit 0 set) are reserved and act exactly like a low enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Synchronization enable |
| grp_all_i | input | 1 | Group select: 0 = units 1-2, 1 = units 1-3 |
| mode_i | input | 3 | Mode code: bit0 reserved, bit1 parallel, bit2 cyclic |
| delay_i | input | 8 | Stagger delay D in cycles |
| trig_i | input | 1 | Trigger event, sampled at each edge |
| stop_i | input | 1 | Stop request for cyclic operation |
| start_o | output | 3 | One-cycle start pulse per unit |
| run_o | output | 3 | Cyclic run level per unit |

## Verification
The bench runs parallel triggers with both group sizes, so a missing or extra unit bit shows up at once. It runs delayed chains with D = 0, 3 and 255, which separates an off-by-one in the spacing from a wrong counter reload. Several patterns test the trigger qualification:
- a trigger held high across whole chains;
- configuration changes in the middle of a chain;
- a stop in the middle of a chain, and a stop in the same cycle as a trigger;
- a low enable;
- every reserved code.

Together these tell apart a block that gates correctly from one that leaks starts or keeps stale run levels. A behavioural model built from a schedule queue predicts both outputs on every cycle.

// File: rtl/sync_trig_pkg.sv
package sync_trig_pkg;

  typedef struct packed {
    logic valid;     // code is not reserved
    logic parallel;  // all units start together
    logic cyclic;    // units keep running until stopped
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] code);
    mode_dec_t d;
    d.valid    = ~code[0];
    d.parallel = code[1];
    d.cyclic   = code[2];
    return d;
  endfunction

endpackage

// File: rtl/sync_rst_sync.sv
module sync_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sync_stagger_seq.sv
module sync_stagger_seq #(
  parameter int N_UNITS = 3,
  parameter int DLY_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               trig,
  input  logic               stop,
  input  logic               grp_all,
  input  logic               parallel,
  input  logic               cyclic,
  input  logic [DLY_W-1:0]   delay,
  output logic [N_UNITS-1:0] start_d,
  output logic               cyc_d,
  output logic [N_UNITS-1:0] start_q
);
  localparam int IW = (N_UNITS > 2) ? $clog2(N_UNITS) : 1;
  localparam logic [N_UNITS-1:0] MASK_ALL   = '1;
  localparam logic [N_UNITS-1:0] MASK_SMALL = MASK_ALL >> 1;
  localparam logic [IW-1:0] IDX_LAST_ALL    = IW'(N_UNITS - 1);
  localparam logic [IW-1:0] IDX_LAST_SMALL  = IW'(N_UNITS - 2);

  logic             busy_q, busy_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [IW-1:0]    last_q, last_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             cyc_q;
  logic             upd;

  // next-state
  always_comb begin
    start_d = '0;
    busy_d  = busy_q;
    idx_d   = idx_q;
    last_d  = last_q;
    cnt_d   = cnt_q;
    dly_d   = dly_q;
    cyc_d   = cyc_q;
    if (!active || stop) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        start_d = N_UNITS'(1) << idx_q;
        cnt_d   = dly_q;
        if (idx_q == last_q) busy_d = 1'b0;
        else                 idx_d  = idx_q + IW'(1);
      end else begin
        cnt_d = cnt_q - DLY_W'(1);
      end
    end else if (trig) begin
      cyc_d = cyclic;
      if (parallel) begin
        start_d = grp_all ? MASK_ALL : MASK_SMALL;
      end else begin
        start_d = N_UNITS'(1);
        busy_d  = 1'b1;
        idx_d   = IW'(1);
        cnt_d   = delay;
        dly_d   = delay;
        last_d  = grp_all ? IDX_LAST_ALL : IDX_LAST_SMALL;
      end
    end
  end

  // chain state only moves while a chain runs or can start
  assign upd = busy_q | (active & trig) | ~active | stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      cnt_q   <= '0;
      dly_q   <= '0;
      cyc_q   <= 1'b0;
      start_q <= '0;
    end else begin
      start_q <= start_d;
      if (upd) begin
        busy_q <= busy_d;
        idx_q  <= idx_d;
        last_q <= last_d;
        cnt_q  <= cnt_d;
        dly_q  <= dly_d;
        cyc_q  <= cyc_d;
      end
    end
  end
endmodule

// File: rtl/sync_run_hold.sv
module sync_run_hold #(
  parameter int N_UNITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               stop,
  input  logic [N_UNITS-1:0] start_d,
  input  logic               cyc_d,
  output logic [N_UNITS-1:0] run_q
);
  logic clr;
  assign clr = ~active | stop;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic run_d;
    logic run_en;

    assign run_en = clr | (start_d[u] & cyc_d);
    assign run_d  = ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q[u] <= 1'b0;
      else if (run_en) run_q[u] <= run_d;
    end
  end
endmodule

// File: rtl/sync_trig_ctrl.sv
module sync_trig_ctrl
  import sync_trig_pkg::*;
#(
  parameter int N_UNITS = 3,
  parameter int DLY_W   = 8,
  parameter int MODE_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               grp_all_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [DLY_W-1:0]   delay_i,
  input  logic               trig_i,
  input  logic               stop_i,
  output logic [N_UNITS-1:0] start_o,
  output logic [N_UNITS-1:0] run_o
);
  logic               rst_n_int;
  mode_dec_t          md;
  logic               active;
  logic [N_UNITS-1:0] start_d;
  logic               cyc_d;

  assign md     = decode_mode(mode_i[2:0]);
  assign active = en_i & md.valid;

  sync_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sync_stagger_seq #(.N_UNITS(N_UNITS), .DLY_W(DLY_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .active   (active),
    .trig     (trig_i),
    .stop     (stop_i),
    .grp_all  (grp_all_i),
    .parallel (md.parallel),
    .cyclic   (md.cyclic),
    .delay    (delay_i),
    .start_d  (start_d),
    .cyc_d    (cyc_d),
    .start_q  (start_o)
  );

  sync_run_hold #(.N_UNITS(N_UNITS)) u_run (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .active  (active),
    .stop    (stop_i),
    .start_d (start_d),
    .cyc_d   (cyc_d),
    .run_q   (run_o)
  );
endmodule

// File: rtl/sync_trig_chk.sv
module sync_trig_chk #(
  parameter int N_UNITS = 3,
  parameter int MODE_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_i,
  input logic [MODE_W-1:0]  mode_i,
  input logic               stop_i,
  input logic [N_UNITS-1:0] start_o,
  input logic [N_UNITS-1:0] run_o
);
  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (start_o == '0 && run_o == '0));

  // R12
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[0] |=> (start_o == '0 && run_o == '0));

  // R10
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (run_o == '0 && start_o == '0));

  // R9
  run_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_o & ~$past(run_o) & ~start_o) == '0));

  // R9
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_o != '0) && en_i && !mode_i[0] && !stop_i) |=> ((run_o & $past(run_o)) == $past(run_o)));
endmodule

bind sync_trig_ctrl sync_trig_chk #(.N_UNITS(N_UNITS), .MODE_W(MODE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (en_i),
  .mode_i  (mode_i),
  .stop_i  (stop_i),
  .start_o (start_o),
  .run_o   (run_o)
);

// File: tb/tb_sync_trig_ctrl.sv
module tb_sync_trig_ctrl;
  localparam int NU = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_i = 1'b0;
  logic          grp_all_i = 1'b0;
  logic [2:0]    mode_i = 3'd0;
  logic [7:0]    delay_i = 8'd0;
  logic          trig_i = 1'b0;
  logic          stop_i = 1'b0;
  logic [NU-1:0] start_o;
  logic [NU-1:0] run_o;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  sync_trig_ctrl dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .grp_all_i(grp_all_i),
    .mode_i(mode_i), .delay_i(delay_i), .trig_i(trig_i), .stop_i(stop_i),
    .start_o(start_o), .run_o(run_o)
  );

  always #4 clk = ~clk;

  // behavioural reference: schedule queue of (edge, unit)
  bit [NU-1:0] m_start, m_run;
  bit          m_cyc;
  int          now = 0;
  int          q_t[$];
  int          q_u[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = '0; m_run = '0; m_cyc = 1'b0;
      q_t.delete(); q_u.delete();
    end else begin
      bit act;
      now++;
      m_start = '0;
      act = en_i && !mode_i[0];
      if (!act || stop_i) begin
        q_t.delete(); q_u.delete(); m_run = '0;
      end else if (q_t.size() > 0) begin
        if (q_t[0] == now) begin
          m_start[q_u[0]] = 1'b1;
          void'(q_t.pop_front()); void'(q_u.pop_front());
        end
      end else if (trig_i) begin
        int n;
        n = grp_all_i ? 3 : 2;
        m_cyc = mode_i[2];
        if (mode_i[1]) begin
          for (int k = 0; k < n; k++) m_start[k] = 1'b1;
        end else begin
          m_start[0] = 1'b1;
          for (int k = 1; k < n; k++) begin
            q_t.push_back(now + k * (int'(delay_i) + 1));
            q_u.push_back(k);
          end
        end
      end
      if (act && !stop_i && m_cyc) m_run |= m_start;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_checks += 2;
      if (start_o !== m_start) begin
        n_fail++;
        $display("FAIL %s start_o got %b exp %b at t=%0t", cur_req, start_o, m_start, $time);
      end
      if (run_o !== m_run) begin
        n_fail++;
        $display("FAIL %s run_o got %b exp %b at t=%0t", cur_req, run_o, m_run, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  task automatic setm(input logic [2:0] m, input logic g, input logic [7:0] d);
    @(negedge clk); mode_i = m; grp_all_i = g; delay_i = d; en_i = 1'b1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1: reset state
    n_checks++;
    if (start_o !== '0 || run_o !== '0) begin
      n_fail++;
      $display("FAIL R1 reset outputs got %b/%b exp 000/000", start_o, run_o);
    end
    cyc(4);
    chk_on = 1'b1;
    cyc(2);

    // R2 / R3 parallel single shot, both groups
    cur_req = "R2"; setm(3'd2, 1'b0, 8'd0); fire(); cyc(4);
    cur_req = "R3"; setm(3'd2, 1'b1, 8'd0); fire(); cyc(4);

    // R4 / R5 delayed chains
    cur_req = "R4"; setm(3'd0, 1'b1, 8'd3); fire(); cyc(14);
    cur_req = "R5"; setm(3'd0, 1'b1, 8'd0); fire(); cyc(6);
    cur_req = "R5"; setm(3'd0, 1'b0, 8'd255); fire(); cyc(262);
    cur_req = "R3"; setm(3'd0, 1'b0, 8'd2); fire(); cyc(8);

    // R6 config changes mid-chain
    cur_req = "R6"; setm(3'd0, 1'b1, 8'd5); fire(); cyc(2);
    delay_i = 8'd1; grp_all_i = 1'b0; mode_i = 3'd2; cyc(16);

    // R7 trigger held across chains
    cur_req = "R7"; setm(3'd0, 1'b1, 8'd4);
    @(negedge clk); trig_i = 1'b1; cyc(30); trig_i = 1'b0; cyc(12);

    // R8 cyclic parallel
    cur_req = "R8"; setm(3'd6, 1'b1, 8'd0); fire(); cyc(10);
    stop_i = 1'b1; cyc(1); stop_i = 1'b0; cyc(3);

    // R9 cyclic delayed
    cur_req = "R9"; setm(3'd4, 1'b1, 8'd2); fire(); cyc(12);
    stop_i = 1'b1; cyc(1); stop_i = 1'b0; cyc(3);

    // R10 stop cancels chain; stop beats trigger
    cur_req = "R10"; setm(3'd4, 1'b1, 8'd6); fire(); cyc(3);
    stop_i = 1'b1; cyc(1); stop_i = 1'b0; cyc(20);
    @(negedge clk); stop_i = 1'b1; trig_i = 1'b1;
    @(negedge clk); stop_i = 1'b0; trig_i = 1'b0; cyc(5);

    // R11 enable low
    cur_req = "R11"; setm(3'd6, 1'b1, 8'd0); fire(); cyc(4);
    @(negedge clk); en_i = 1'b0; cyc(3);
    fire(); cyc(4);
    setm(3'd0, 1'b1, 8'd3); fire(); cyc(2);
    en_i = 1'b0; cyc(12);

    // R12 reserved codes
    cur_req = "R12";
    for (int m = 1; m < 8; m += 2) begin
      setm(3'(m), 1'b1, 8'd1); fire(); cyc(8);
    end
    setm(3'd6, 1'b1, 8'd0); fire(); cyc(3);
    @(negedge clk); mode_i = 3'd7; cyc(4);

    chk_on = 1'b0;
    finish_run();
  end
endmodule